// File: doc/BRIEF.md
# Nibble Stack-Top ALU with Condition Flags

This block is the arithmetic and flag unit of a zero-address, stack-based 4-bit processor core. Each executed operation reads the top of the expression stack (TOS) and the entry below it (NOS). It computes a 4-bit result and writes it back into the TOS register. Alongside the result the block keeps a 4-bit condition code register. That register holds a carry/borrow flag, a branch flag, an interrupt-enable flag and one reserved bit. Each operation class updates these flags in its own way.

The surrounding core supplies the two stack nibbles and an opcode, and pulses `exec_en` for one cycle per executed instruction. The interrupt-enable instructions arrive as two strobes. The conditional-branch logic of the core asks `jump_taken` whether a jump should happen. Stack-pointer handling, memory access, instruction fetch and interrupt arbitration sit outside this block.

Top module: `nib_stack_alu`

## Requirements
- R1: Opcode 1 (add) writes (NOS + TOS) mod 16 to TOS and sets carry to the fifth bit of the sum. Opcode 2 (add with carry) also adds the old carry.
- R2: Opcode 3 (subtract) writes (NOS − TOS) mod 16 to TOS and sets carry to 1 exactly when a borrow occurs. Opcode 4 (subtract with borrow) also subtracts the old carry.
- R3: For opcodes 1 to 8, the branch flag afterwards is 1 exactly when the new 4-bit TOS is zero.
- R4: Opcodes 5 (AND), 6 (OR), 7 (XOR) of NOS and TOS, and opcode 8 (invert TOS), write their result to TOS and leave carry unchanged.
- R5: Opcode 9 (shift left) and opcode 10 (shift right) shift TOS by one place and fill with 0. The bit shifted out is copied into both carry and branch.
- R6: Opcode 11 (rotate left) and opcode 12 (rotate right) rotate TOS through carry. The old carry enters the vacated bit, and the bit shifted out goes into both carry and branch.
- R7: Opcode 13 sets branch and carry to 1, and opcode 14 inverts branch. Both leave TOS and the other flags unchanged. Opcode 0 changes nothing.
- R8: Opcode 15 loads the flags from TOS: carry from bit 0, branch from bit 1 and interrupt enable from bit 2. TOS is unchanged. The flag output packs carry in bit 0, branch in bit 1 and interrupt enable in bit 2, and bit 3 always reads 0.
- R9: When `ie_clr` is high during an executed cycle, interrupt enable becomes 0. Otherwise, when `ie_set` is high, it becomes 1. Both strobes take priority over a load through opcode 15.
- R10: While `exec_en` is low, TOS and all flags keep their values whatever the other inputs are.
- R11: `jump_taken` is high exactly when `cond_br` is high and the branch flag is 1.
- R12: Synchronous reset clears TOS and every flag, including interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Execute strobe; registers update only while high |
| opcode | input | 4 | Operation select (encodings in R1–R8) |
| tos_in | input | 4 | Current top-of-stack nibble |
| nos_in | input | 4 | Stack entry below the top |
| ie_set | input | 1 | Enable-interrupt / return / sleep strobe |
| ie_clr | input | 1 | Disable-interrupt strobe |
| cond_br | input | 1 | A conditional branch is being evaluated |
| tos_out | output | 4 | Registered result written back to TOS |
| ccr_out | output | 4 | Packed flags: bit 0 carry, bit 1 branch, bit 2 interrupt enable, bit 3 zero |
| carry | output | 1 | Carry/borrow flag |
| branch | output | 1 | Branch flag |
| int_en | output | 1 | Interrupt-enable flag |
| jump_taken | output | 1 | Conditional branch decision |

## Verification
Interrupt enable has two possible writers in a single executed cycle: the flag-load opcode and the strobes. The bench issues opcode 15 with a TOS whose bit 2 disagrees with the asserted strobe. It also raises `ie_set` and `ie_clr` together. In each case it reads `int_en` on the following cycle and expects the strobe to decide. In the same way, every opcode is run with every TOS, NOS and incoming carry/branch value, and the flags that the opcode must leave alone are checked as well as the flags it writes.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

    parameter int unsigned NIB_W = 4;
    localparam int unsigned CCR_W = 4;
    localparam int unsigned SUM_W = NIB_W + 1;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [SUM_W-1:0] sum_t;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_ADD   = 4'd1,
        OP_ADDC  = 4'd2,
        OP_SUB   = 4'd3,
        OP_SUBB  = 4'd4,
        OP_AND   = 4'd5,
        OP_OR    = 4'd6,
        OP_XOR   = 4'd7,
        OP_NOT   = 4'd8,
        OP_SHL   = 4'd9,
        OP_SHR   = 4'd10,
        OP_ROL   = 4'd11,
        OP_ROR   = 4'd12,
        OP_SETBC = 4'd13,
        OP_TOGB  = 4'd14,
        OP_LDCCR = 4'd15
    } alu_op_e;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_ARITH,
        CL_BOOL,
        CL_SHIFT,
        CL_FLAG
    } op_class_e;

    // bit 0 carry, bit 1 branch, bit 2 interrupt enable, bit 3 reserved
    typedef struct packed {
        logic rsvd;
        logic ie;
        logic br;
        logic cy;
    } ccr_t;

    typedef struct packed {
        nib_t value;
        logic cy;
        logic br;
        logic wr_cy;
        logic wr_br;
    } alu_res_t;

    function automatic op_class_e classify(alu_op_e op);
        case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBB:  return CL_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_NOT:     return CL_BOOL;
            OP_SHL, OP_SHR, OP_ROL, OP_ROR:    return CL_SHIFT;
            OP_SETBC, OP_TOGB, OP_LDCCR:       return CL_FLAG;
            default:                           return CL_NONE;
        endcase
    endfunction

    function automatic logic is_zero(nib_t v);
        return (v == '0);
    endfunction

endpackage

// File: rtl/nib_alu_core.sv
module nib_alu_core
    import nib_alu_pkg::*;
(
    input  alu_op_e  op,
    input  nib_t     tos,
    input  nib_t     nos,
    input  logic     cy_in,
    output alu_res_t res
);

    sum_t      wide;
    logic      cin_eff;
    op_class_e cls;

    assign cls     = classify(op);
    assign cin_eff = ((op == OP_ADDC) || (op == OP_SUBB)) ? cy_in : 1'b0;

    always_comb begin
        wide = '0;
        if (op == OP_ADD || op == OP_ADDC)
            wide = {1'b0, nos} + {1'b0, tos} + {{NIB_W{1'b0}}, cin_eff};
        else if (op == OP_SUB || op == OP_SUBB)
            wide = {1'b0, nos} - {1'b0, tos} - {{NIB_W{1'b0}}, cin_eff};
    end

    always_comb begin
        res.value = tos;
        res.cy    = cy_in;
        res.br    = 1'b0;
        res.wr_cy = 1'b0;
        res.wr_br = 1'b0;
        case (cls)
            CL_ARITH: begin
                res.value = wide[NIB_W-1:0];
                res.cy    = wide[NIB_W];
                res.br    = is_zero(wide[NIB_W-1:0]);
                res.wr_cy = 1'b1;
                res.wr_br = 1'b1;
            end
            CL_BOOL: begin
                case (op)
                    OP_AND:  res.value = nos & tos;
                    OP_OR:   res.value = nos | tos;
                    OP_XOR:  res.value = nos ^ tos;
                    default: res.value = ~tos;
                endcase
                res.br    = is_zero(res.value);
                res.wr_br = 1'b1;
            end
            CL_SHIFT: begin
                case (op)
                    OP_SHL: begin
                        res.value = {tos[NIB_W-2:0], 1'b0};
                        res.cy    = tos[NIB_W-1];
                    end
                    OP_SHR: begin
                        res.value = {1'b0, tos[NIB_W-1:1]};
                        res.cy    = tos[0];
                    end
                    OP_ROL: begin
                        res.value = {tos[NIB_W-2:0], cy_in};
                        res.cy    = tos[NIB_W-1];
                    end
                    default: begin
                        res.value = {cy_in, tos[NIB_W-1:1]};
                        res.cy    = tos[0];
                    end
                endcase
                res.br    = res.cy;
                res.wr_cy = 1'b1;
                res.wr_br = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nib_ccr.sv
module nib_ccr
    import nib_alu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     exec_en,
    input  alu_op_e  op,
    input  alu_res_t res,
    input  logic [2:0] ld_bits,
    input  logic     ie_set,
    input  logic     ie_clr,
    output ccr_t     ccr
);

    ccr_t ccr_q;
    ccr_t ccr_nxt;

    always_comb begin
        ccr_nxt = ccr_q;
        if (res.wr_cy) ccr_nxt.cy = res.cy;
        if (res.wr_br) ccr_nxt.br = res.br;
        case (op)
            OP_SETBC: begin
                ccr_nxt.cy = 1'b1;
                ccr_nxt.br = 1'b1;
            end
            OP_TOGB:  ccr_nxt.br = ~ccr_q.br;
            OP_LDCCR: begin
                ccr_nxt.cy = ld_bits[0];
                ccr_nxt.br = ld_bits[1];
                ccr_nxt.ie = ld_bits[2];
            end
            default: ;
        endcase
        if (ie_clr)
            ccr_nxt.ie = 1'b0;
        else if (ie_set)
            ccr_nxt.ie = 1'b1;
        ccr_nxt.rsvd = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ccr_q <= '0;
        else if (exec_en)
            ccr_q <= ccr_nxt;
    end

    assign ccr = ccr_q;

    AST_BOOL_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
        (exec_en && classify(op) == CL_BOOL) |=> $stable(ccr_q.cy)); // R4

    AST_IE_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (exec_en && ie_clr) |=> !ccr_q.ie); // R9

    AST_IE_SET_OVER_LOAD: assert property (@(posedge clk) disable iff (rst)
        (exec_en && ie_set && !ie_clr) |=> ccr_q.ie); // R9

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !exec_en |=> $stable(ccr_q)); // R10

endmodule

// File: rtl/nib_stack_alu.sv
module nib_stack_alu
    import nib_alu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             exec_en,
    input  logic [3:0]       opcode,
    input  logic [NIB_W-1:0] tos_in,
    input  logic [NIB_W-1:0] nos_in,
    input  logic             ie_set,
    input  logic             ie_clr,
    input  logic             cond_br,
    output logic [NIB_W-1:0] tos_out,
    output logic [CCR_W-1:0] ccr_out,
    output logic             carry,
    output logic             branch,
    output logic             int_en,
    output logic             jump_taken
);

    alu_op_e  op;
    alu_res_t res;
    ccr_t     flags;
    nib_t     tos_q;

    assign op = alu_op_e'(opcode);

    nib_alu_core u_core (
        .op    (op),
        .tos   (tos_in),
        .nos   (nos_in),
        .cy_in (flags.cy),
        .res   (res)
    );

    nib_ccr u_ccr (
        .clk     (clk),
        .rst     (rst),
        .exec_en (exec_en),
        .op      (op),
        .res     (res),
        .ld_bits (tos_in[2:0]),
        .ie_set  (ie_set),
        .ie_clr  (ie_clr),
        .ccr     (flags)
    );

    always_ff @(posedge clk) begin
        if (rst)
            tos_q <= '0;
        else if (exec_en)
            tos_q <= res.value;
    end

    assign tos_out    = tos_q;
    assign ccr_out    = flags;
    assign carry      = flags.cy;
    assign branch     = flags.br;
    assign int_en     = flags.ie;
    assign jump_taken = cond_br & flags.br;

    AST_ZERO_BRANCH: assert property (@(posedge clk) disable iff (rst)
        (exec_en && (classify(op) == CL_ARITH || classify(op) == CL_BOOL))
        |=> (branch == (tos_out == '0))); // R3

    AST_SHIFT_OUT_CARRY: assert property (@(posedge clk) disable iff (rst)
        (exec_en && (op == OP_SHL || op == OP_ROL))
        |=> (carry == $past(tos_in[NIB_W-1]) && branch == carry)); // R5

    AST_TOS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !exec_en |=> $stable(tos_out)); // R10

    AST_FLAG_OPS_KEEP_TOS: assert property (@(posedge clk) disable iff (rst)
        (exec_en && classify(op) == CL_FLAG) |=> (tos_out == $past(tos_in))); // R7

endmodule

// File: tb/nib_stack_alu_bench.sv
`timescale 1ns/1ps
module nib_stack_alu_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       exec_en;
    logic [3:0] opcode;
    logic [3:0] tos_in;
    logic [3:0] nos_in;
    logic       ie_set;
    logic       ie_clr;
    logic       cond_br;
    logic [3:0] tos_out;
    logic [3:0] ccr_out;
    logic       carry;
    logic       branch;
    logic       int_en;
    logic       jump_taken;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    nib_stack_alu u_nib_stack_alu (
        .clk        (clk),
        .rst        (rst),
        .exec_en    (exec_en),
        .opcode     (opcode),
        .tos_in     (tos_in),
        .nos_in     (nos_in),
        .ie_set     (ie_set),
        .ie_clr     (ie_clr),
        .cond_br    (cond_br),
        .tos_out    (tos_out),
        .ccr_out    (ccr_out),
        .carry      (carry),
        .branch     (branch),
        .int_en     (int_en),
        .jump_taken (jump_taken)
    );

    function automatic string req_of(int op);
        case (op)
            1, 2:           return "R1";
            3, 4:           return "R2";
            5, 6, 7, 8:     return "R4";
            9, 10:          return "R5";
            11, 12:         return "R6";
            15:             return "R8";
            default:        return "R7";
        endcase
    endfunction

    // returns {tos, ccr} expected after one executed op
    function automatic logic [7:0] model(int op, logic [3:0] t, logic [3:0] n,
                                         logic c, logic b, logic ie);
        int   s;
        logic [3:0] r  = t;
        logic       nc = c;
        logic       nb = b;
        logic       ni = ie;
        s = 0;
        case (op)
            1, 2: begin
                s  = int'(n) + int'(t) + ((op == 2) ? int'(c) : 0);
                r  = 4'(s % 16);
                nc = (s > 15);
                nb = (r == 4'd0);
            end
            3, 4: begin
                s  = int'(n) - int'(t) - ((op == 4) ? int'(c) : 0);
                r  = 4'((s + 32) % 16);
                nc = (s < 0);
                nb = (r == 4'd0);
            end
            5: begin r = n & t; nb = (r == 4'd0); end
            6: begin r = n | t; nb = (r == 4'd0); end
            7: begin r = n ^ t; nb = (r == 4'd0); end
            8: begin r = 4'(15 - int'(t)); nb = (r == 4'd0); end
            9:  begin r = 4'((int'(t) * 2) % 16);            nc = t[3]; nb = t[3]; end
            10: begin r = 4'(int'(t) / 2);                   nc = t[0]; nb = t[0]; end
            11: begin r = 4'((int'(t) * 2) % 16 + int'(c));  nc = t[3]; nb = t[3]; end
            12: begin r = 4'(int'(t) / 2 + 8 * int'(c));     nc = t[0]; nb = t[0]; end
            13: begin nc = 1'b1; nb = 1'b1; end
            14: nb = ~b;
            15: begin nc = t[0]; nb = t[1]; ni = t[2]; end
            default: ;
        endcase
        return {r, 1'b0, ni, nb, nc};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual {tos,ccr}=%h expected %h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic step(logic ex, logic [3:0] op, logic [3:0] t, logic [3:0] n,
                        logic s, logic c);
        exec_en = ex; opcode = op; tos_in = t; nos_in = n; ie_set = s; ie_clr = c;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; exec_en = 1'b0; opcode = 4'd0; tos_in = 4'd0; nos_in = 4'd0;
        ie_set = 1'b0; ie_clr = 1'b0; cond_br = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R12 reset", {tos_out, ccr_out}, 8'h00);

        // exhaustive sweep: preset flags through a load, then run the op
        for (int op = 0; op < 16; op++) begin
            for (int t = 0; t < 16; t++) begin
                for (int n = 0; n < 16; n++) begin
                    for (int cb = 0; cb < 4; cb++) begin
                        logic pc, pb, pi;
                        pc = cb[0]; pb = cb[1]; pi = t[0] ^ n[0];
                        step(1'b1, 4'd15, {1'b0, pi, pb, pc}, 4'd0, 1'b0, 1'b0);
                        if (op == 0 && t == 0) begin
                            cond_br = 1'b1; #0.5;
                            check("R11 cond high", {7'd0, jump_taken}, {7'd0, pb});
                            cond_br = 1'b0; #0.5;
                            check("R11 cond low", {7'd0, jump_taken}, 8'd0);
                        end
                        step(1'b1, 4'(op), 4'(t), 4'(n), 1'b0, 1'b0);
                        check(req_of(op), {tos_out, ccr_out},
                              model(op, 4'(t), 4'(n), pc, pb, pi));
                    end
                end
            end
        end

        // interrupt-enable strobes, alone and competing with the flag load
        step(1'b1, 4'd15, 4'd0, 4'd0, 1'b0, 1'b0);
        step(1'b1, 4'd0, 4'd5, 4'd0, 1'b1, 1'b0);
        check("R9 set", {tos_out, ccr_out}, 8'h54);
        step(1'b1, 4'd0, 4'd5, 4'd0, 1'b0, 1'b1);
        check("R9 clear", {tos_out, ccr_out}, 8'h50);
        step(1'b1, 4'd0, 4'd5, 4'd0, 1'b1, 1'b0);
        step(1'b1, 4'd0, 4'd5, 4'd0, 1'b1, 1'b1);
        check("R9 both strobes", {tos_out, ccr_out}, 8'h50);
        step(1'b1, 4'd15, 4'd7, 4'd0, 1'b0, 1'b1);
        check("R9 clear over load", {tos_out, ccr_out}, 8'h73);
        step(1'b1, 4'd15, 4'd0, 4'd0, 1'b1, 1'b0);
        check("R9 set over load", {tos_out, ccr_out}, 8'h04);

        // execute strobe low: nothing moves
        step(1'b1, 4'd15, 4'd7, 4'd0, 1'b0, 1'b0);
        step(1'b1, 4'd1, 4'd9, 4'd9, 1'b0, 1'b0);
        for (int op = 0; op < 16; op++) begin
            step(1'b0, 4'(op), 4'd15, 4'd15, op[0], op[1]);
            check("R10 hold", {tos_out, ccr_out}, 8'h25);
        end

        // reset after activity
        step(1'b1, 4'd13, 4'd6, 4'd0, 1'b1, 1'b0);
        rst = 1'b1;
        step(1'b1, 4'd1, 4'd3, 4'd3, 1'b1, 1'b0);
        rst = 1'b0;
        check("R12 reset after use", {tos_out, ccr_out}, 8'h00);

        finish_run();
    end

endmodule